// File: doc/BRIEF.md
# Dual Multiply-Accumulate Unit

Two 16x16 multiply-accumulate lanes run side by side from one pair of 32-bit source words. Each lane keeps a 40-bit accumulator: a 32-bit word with an 8-bit sign-extension byte above it. Each lane chooses which 16-bit half of each source feeds its multiplier. Per lane, the operation code holds the accumulator, loads the product into it, adds the product, or subtracts it.

A shared mode bit selects fractional arithmetic (product doubled) or integer arithmetic. Each lane may also extract its updated accumulator for a register file. A 16-bit extraction places lane 1's value in the high half and lane 0's value in the low half of one destination register. A 32-bit extraction writes lane 1 to the odd register and lane 0 to the even register of an aligned pair. Extracted values are clamped to the signed range of the target width. In fractional 16-bit extraction, an optional rounding step applies first.

An issue strobe is registered once. Accumulators and write-back fields change on the clock edge that samples the strobe.

Top module: `dual_mac`

## Requirements
- R1: After reset both accumulators are zero and both write masks are 2'b00.
- R2: A lane's select bit picks the high half (1) or low half (0) of its source word, and the two halves are multiplied as signed 16-bit values; all four combinations work for each lane independently.
- R3: Operation code per lane: 0 holds the accumulator, 1 loads the product, 2 adds the product, 3 subtracts the product. The accumulator is 40 bits and wraps modulo 2^40.
- R4: With frac=1 the product is shifted left by one before use; with frac=0 it is used unshifted.
- R5: With frac=1, the halves 0x8000 times 0x8000 give the product 0x7FFFFFFF.
- R6: A 16-bit fractional extraction adds 0x8000 to the new accumulator value when rnd=1. It then takes bits [31:16], or 0x7FFF / 0x8000 if the sum lies outside the signed 32-bit range.
- R7: A 16-bit integer extraction takes bits [15:0] of the new accumulator value, or 0x7FFF / 0x8000 if the value lies outside the signed 16-bit range. rnd has no effect on it.
- R8: In 16-bit extraction (wide=0), both lanes target register dst. Lane 1 writes the high half (mask 2'b10, value in data bits [31:16], low bits zero). Lane 0 writes the low half (mask 2'b01, value in data bits [15:0], high bits zero).
- R9: In 32-bit extraction (wide=1), each lane writes the new accumulator value clamped to the signed 32-bit range, with mask 2'b11 and no rounding. Lane 1 targets register {dst[2:1],1} and lane 0 targets {dst[2:1],0}.
- R10: A lane with its extract bit clear still performs its operation but reports mask 2'b00, while the other lane extracts in the same issue.
- R11: Accumulators and write-back outputs take their new values at the clock edge that samples issue=1. With issue=0 the accumulators keep their values and both masks read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Perform the operation described by the other inputs this cycle |
| src_a | input | 32 | First source word, two 16-bit halves |
| src_b | input | 32 | Second source word, two 16-bit halves |
| op1 | input | 2 | Lane 1 operation code |
| op0 | input | 2 | Lane 0 operation code |
| sel_a1 | input | 1 | Lane 1 half of src_a (1 = high) |
| sel_b1 | input | 1 | Lane 1 half of src_b (1 = high) |
| sel_a0 | input | 1 | Lane 0 half of src_a (1 = high) |
| sel_b0 | input | 1 | Lane 0 half of src_b (1 = high) |
| ext1 | input | 1 | Lane 1 extracts a result |
| ext0 | input | 1 | Lane 0 extracts a result |
| frac | input | 1 | Fractional (1) or integer (0) arithmetic |
| rnd | input | 1 | Round fractional 16-bit extraction |
| wide | input | 1 | 32-bit (1) or 16-bit (0) extraction |
| dst | input | 3 | Destination register index |
| acc1 | output | 40 | Lane 1 accumulator |
| acc0 | output | 40 | Lane 0 accumulator |
| rf_idx1 | output | 3 | Register written by lane 1 |
| rf_idx0 | output | 3 | Register written by lane 0 |
| rf_data1 | output | 32 | Lane 1 write data |
| rf_data0 | output | 32 | Lane 0 write data |
| rf_mask1 | output | 2 | Lane 1 half enables (bit 1 high, bit 0 low) |
| rf_mask0 | output | 2 | Lane 0 half enables (bit 1 high, bit 0 low) |

## Verification
The main sweep crosses eight 16-bit values at the range corners, zero, one and mid-scale in every position of both sources. It uses all four half selections per lane, and the two lanes read different halves. This separates a wrong half choice, a sign error and a swapped lane. The same sweep alternates fractional and integer mode, rounding, narrow and wide extraction, and the operation codes. This shows whether the doubling, the bit window and the 0x8000 offset are applied in the right mode only. A long run adds the saturated fractional product several hundred times, which pushes the accumulator through the signed 32-bit limit, through the guard byte, and through the 40-bit wrap. Meanwhile the other lane holds and extracts, which confirms clamping at every width and lane independence. Idle cycles with live operation codes on the pins check that nothing moves without the strobe.

// File: rtl/dual_mac.sv
module dual_mac #(
  parameter int OPW   = 16,
  parameter int GUARD = 8,
  parameter int NREG  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue,
  input  logic [2*OPW-1:0]              src_a,
  input  logic [2*OPW-1:0]              src_b,
  input  logic [1:0]                    op1,
  input  logic [1:0]                    op0,
  input  logic                          sel_a1,
  input  logic                          sel_b1,
  input  logic                          sel_a0,
  input  logic                          sel_b0,
  input  logic                          ext1,
  input  logic                          ext0,
  input  logic                          frac,
  input  logic                          rnd,
  input  logic                          wide,
  input  logic [$clog2(NREG)-1:0]       dst,
  output logic [2*OPW+GUARD-1:0]        acc1,
  output logic [2*OPW+GUARD-1:0]        acc0,
  output logic [$clog2(NREG)-1:0]       rf_idx1,
  output logic [$clog2(NREG)-1:0]       rf_idx0,
  output logic [2*OPW-1:0]              rf_data1,
  output logic [2*OPW-1:0]              rf_data0,
  output logic [1:0]                    rf_mask1,
  output logic [1:0]                    rf_mask0
);
  localparam int PW = 2*OPW;
  localparam int AW = PW + GUARD;
  localparam int IW = $clog2(NREG);
  localparam logic [OPW-1:0] MAXH = {1'b0, {(OPW-1){1'b1}}};
  localparam logic [OPW-1:0] MINH = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [PW-1:0]  MAXW = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0]  MINW = {1'b1, {(PW-1){1'b0}}};
  localparam logic [AW:0]    RINC = (AW+1)'(1) << (OPW-1);

  logic [3:0] opv;
  logic [1:0] sav, sbv, exv;
  assign opv = {op1, op0};
  assign sav = {sel_a1, sel_a0};
  assign sbv = {sel_b1, sel_b0};
  assign exv = {ext1, ext0};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [OPW-1:0] ha, hb;
    logic signed [PW-1:0]  raw;
    logic [PW-1:0]         prod, wid, put;
    logic [AW-1:0]         prod_x, nxt, acc_r;
    logic [AW:0]           rsum;
    logic [OPW-1:0]        nar_f, nar_i, nar;
    logic                  fit_f, fit_i, fit_w;
    logic [1:0]            hmask;
    logic [PW-1:0]         dat_r;
    logic [IW-1:0]         idx_r;
    logic [1:0]            msk_r;

    assign ha     = sav[l] ? src_a[PW-1:OPW] : src_a[OPW-1:0];
    assign hb     = sbv[l] ? src_b[PW-1:OPW] : src_b[OPW-1:0];
    assign raw    = ha * hb;
    assign prod   = !frac ? raw : ((ha == MINH && hb == MINH) ? MAXW : raw <<< 1);
    assign prod_x = {{GUARD{prod[PW-1]}}, prod};

    always_comb begin
      case (opv[2*l +: 2])
        2'd1:    nxt = prod_x;
        2'd2:    nxt = acc_r + prod_x;
        2'd3:    nxt = acc_r - prod_x;
        default: nxt = acc_r;
      endcase
    end

    assign rsum  = {nxt[AW-1], nxt} + ((frac && rnd) ? RINC : '0);
    assign fit_f = &rsum[AW:PW-1] | ~|rsum[AW:PW-1];
    assign nar_f = fit_f ? rsum[PW-1:OPW] : (rsum[AW] ? MINH : MAXH);
    assign fit_i = &nxt[AW-1:OPW-1] | ~|nxt[AW-1:OPW-1];
    assign nar_i = fit_i ? nxt[OPW-1:0] : (nxt[AW-1] ? MINH : MAXH);
    assign fit_w = &nxt[AW-1:PW-1] | ~|nxt[AW-1:PW-1];
    assign wid   = fit_w ? nxt[PW-1:0] : (nxt[AW-1] ? MINW : MAXW);
    assign nar   = frac ? nar_f : nar_i;

    if (l == 1) begin : g_hi
      assign put   = wide ? wid : {nar, {OPW{1'b0}}};
      assign hmask = wide ? 2'b11 : 2'b10;
    end else begin : g_lo
      assign put   = wide ? wid : {{OPW{1'b0}}, nar};
      assign hmask = wide ? 2'b11 : 2'b01;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_r <= '0;
        dat_r <= '0;
        idx_r <= '0;
        msk_r <= '0;
      end else if (issue) begin
        acc_r <= nxt;
        msk_r <= exv[l] ? hmask : 2'b00;
        if (exv[l]) begin
          dat_r <= put;
          idx_r <= wide ? {dst[IW-1:1], 1'(l)} : dst;
        end
      end else begin
        msk_r <= 2'b00;
      end
    end
  end

  assign acc1     = g_lane[1].acc_r;
  assign acc0     = g_lane[0].acc_r;
  assign rf_data1 = g_lane[1].dat_r;
  assign rf_data0 = g_lane[0].dat_r;
  assign rf_idx1  = g_lane[1].idx_r;
  assign rf_idx0  = g_lane[0].idx_r;
  assign rf_mask1 = g_lane[1].msk_r;
  assign rf_mask0 = g_lane[0].msk_r;
endmodule

module dual_mac_chk #(
  parameter int AW = 40,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [1:0]    op1,
  input logic [1:0]    op0,
  input logic          ext1,
  input logic          ext0,
  input logic          wide,
  input logic [AW-1:0] acc1,
  input logic [AW-1:0] acc0,
  input logic [IW-1:0] rf_idx1,
  input logic [IW-1:0] rf_idx0,
  input logic [1:0]    rf_mask1,
  input logic [1:0]    rf_mask0
);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(acc1) && $stable(acc0) && rf_mask1 == 2'b00 && rf_mask0 == 2'b00));

  assert_op_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op1 == 2'd0 && op0 == 2'd0) |=> ($stable(acc1) && $stable(acc0)));

  assert_lane_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_mask1 != 2'b01) && (rf_mask0 != 2'b10));

  assert_same_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !wide && ext1 && ext0) |=> (rf_idx1 == rf_idx0));

  assert_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && wide && ext1 && ext0) |=> (rf_idx1[0] && !rf_idx0[0] &&
                                         rf_idx1[IW-1:1] == rf_idx0[IW-1:1]));

  assert_no_extract_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !ext1) |=> (rf_mask1 == 2'b00));
endmodule

bind dual_mac dual_mac_chk #(.AW(2*OPW+GUARD), .IW($clog2(NREG))) chk_i (
  .clk(clk), .rst_n(rst_n), .issue(issue), .op1(op1), .op0(op0),
  .ext1(ext1), .ext0(ext0), .wide(wide), .acc1(acc1), .acc0(acc0),
  .rf_idx1(rf_idx1), .rf_idx0(rf_idx0), .rf_mask1(rf_mask1), .rf_mask0(rf_mask0)
);

// File: tb/dual_mac_tb.sv
module dual_mac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [1:0]  op1 = '0, op0 = '0;
  logic        sel_a1 = 0, sel_b1 = 0, sel_a0 = 0, sel_b0 = 0;
  logic        ext1 = 0, ext0 = 0, frac = 0, rnd = 0, wide = 0;
  logic [2:0]  dst = '0;
  logic [39:0] acc1, acc0;
  logic [2:0]  rf_idx1, rf_idx0;
  logic [31:0] rf_data1, rf_data0;
  logic [1:0]  rf_mask1, rf_mask0;

  int checks = 0, fails = 0;
  longint m1 = 0, m0 = 0;

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                       16'hFFFF, 16'h4000, 16'hC000, 16'h1234};

  always #5 clk = ~clk;

  dual_mac dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .src_a(src_a), .src_b(src_b),
    .op1(op1), .op0(op0), .sel_a1(sel_a1), .sel_b1(sel_b1), .sel_a0(sel_a0),
    .sel_b0(sel_b0), .ext1(ext1), .ext0(ext0), .frac(frac), .rnd(rnd),
    .wide(wide), .dst(dst), .acc1(acc1), .acc0(acc0), .rf_idx1(rf_idx1),
    .rf_idx0(rf_idx0), .rf_data1(rf_data1), .rf_data0(rf_data0),
    .rf_mask1(rf_mask1), .rf_mask0(rf_mask0)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint wrap40(longint v);
    logic [39:0] t = v[39:0];
    return longint'($signed(t));
  endfunction

  function automatic longint mprod(logic [15:0] a, logic [15:0] b, bit fr);
    longint p = longint'($signed(a)) * longint'($signed(b));
    if (!fr) return p;
    if (a == 16'h8000 && b == 16'h8000) return 64'sh7FFFFFFF;
    return p * 2;
  endfunction

  function automatic logic [15:0] nar16(longint acc, bit fr, bit rd);
    longint r;
    if (fr) begin
      r = acc + (rd ? 64'sd32768 : 64'sd0);
      if (r > 64'sd2147483647)  return 16'h7FFF;
      if (r < -64'sd2147483648) return 16'h8000;
      return r[31:16];
    end
    if (acc > 64'sd32767)  return 16'h7FFF;
    if (acc < -64'sd32768) return 16'h8000;
    return acc[15:0];
  endfunction

  function automatic logic [31:0] wid32(longint acc);
    if (acc > 64'sd2147483647)  return 32'h7FFFFFFF;
    if (acc < -64'sd2147483648) return 32'h80000000;
    return acc[31:0];
  endfunction

  function automatic longint step(longint acc, logic [1:0] op, longint p);
    case (op)
      2'd1:    return wrap40(p);
      2'd2:    return wrap40(acc + p);
      2'd3:    return wrap40(acc - p);
      default: return acc;
    endcase
  endfunction

  // Called at a negedge; returns at the next negedge after checking.
  task automatic run(logic [1:0] o1, logic [1:0] o0, logic [3:0] sels, bit e1, bit e0,
                     bit fr, bit rd, bit wd, logic [2:0] d, logic [31:0] a, logic [31:0] b);
    logic [15:0] h1a, h1b, h0a, h0b;
    logic [1:0] em1, em0;
    logic [31:0] ed1, ed0;
    logic [2:0] ei1, ei0;
    op1 = o1; op0 = o0; {sel_a1, sel_b1, sel_a0, sel_b0} = sels;
    ext1 = e1; ext0 = e0; frac = fr; rnd = rd; wide = wd; dst = d;
    src_a = a; src_b = b; issue = 1'b1;
    h1a = sels[3] ? a[31:16] : a[15:0];
    h1b = sels[2] ? b[31:16] : b[15:0];
    h0a = sels[1] ? a[31:16] : a[15:0];
    h0b = sels[0] ? b[31:16] : b[15:0];
    m1 = step(m1, o1, mprod(h1a, h1b, fr));
    m0 = step(m0, o0, mprod(h0a, h0b, fr));
    em1 = e1 ? (wd ? 2'b11 : 2'b10) : 2'b00;
    em0 = e0 ? (wd ? 2'b11 : 2'b01) : 2'b00;
    ed1 = wd ? wid32(m1) : {nar16(m1, fr, rd), 16'h0000};
    ed0 = wd ? wid32(m0) : {16'h0000, nar16(m0, fr, rd)};
    ei1 = wd ? {d[2:1], 1'b1} : d;
    ei0 = wd ? {d[2:1], 1'b0} : d;
    @(negedge clk);
    issue = 1'b0;
    chk("R2/R3/R4/R5 acc1", 64'(acc1), 64'(m1[39:0]));
    chk("R2/R3/R4/R5 acc0", 64'(acc0), 64'(m0[39:0]));
    chk("R8/R9/R10 mask1", 64'(rf_mask1), 64'(em1));
    chk("R8/R9/R10 mask0", 64'(rf_mask0), 64'(em0));
    if (e1) begin
      chk(wd ? "R9 data1" : (fr ? "R6 data1" : "R7 data1"), 64'(rf_data1), 64'(ed1));
      chk(wd ? "R9 idx1" : "R8 idx1", 64'(rf_idx1), 64'(ei1));
    end
    if (e0) begin
      chk(wd ? "R9 data0" : (fr ? "R6 data0" : "R7 data0"), 64'(rf_data0), 64'(ed0));
      chk(wd ? "R9 idx0" : "R8 idx0", 64'(rf_idx0), 64'(ei0));
    end
  endtask

  task automatic idle();
    op1 = 2'd1; op0 = 2'd2; ext1 = 1; ext0 = 1; src_a = 32'h7FFF8000; src_b = 32'h12345678;
    issue = 1'b0;
    @(negedge clk);
    chk("R11 idle acc1", 64'(acc1), 64'(m1[39:0]));
    chk("R11 idle acc0", 64'(acc0), 64'(m0[39:0]));
    chk("R11 idle masks", 64'({rf_mask1, rf_mask0}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset acc1", 64'(acc1), 64'd0);
    chk("R1 reset acc0", 64'(acc0), 64'd0);
    chk("R1 reset masks", 64'({rf_mask1, rf_mask0}), 64'd0);

    // R5 corner directly, then R4 integer of same operands
    run(2'd1, 2'd1, 4'b1100, 1, 1, 1, 0, 1, 3'd2, 32'h80000000, 32'h80000000);
    run(2'd1, 2'd1, 4'b1100, 1, 1, 0, 0, 1, 3'd5, 32'h80000000, 32'h80000000);
    idle();

    // Main sweep (R2, R3, R4, R6, R7, R8, R9, R10)
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        for (int s = 0; s < 4; s++) begin
          logic [3:0] sl;
          logic [1:0] o1, o0;
          sl = {2'(s), 2'((s + 1) % 4)};
          o1 = (s == 0) ? 2'd1 : 2'(s);
          o0 = (ia == 0) ? 2'd0 : 2'(((s + ia) % 3) + 1);
          run(o1, o0, sl, 1, s != 3, ib[0], ia[1], s[1] ^ ia[0], 3'((ia + ib) % 8),
              {VALS[ia], VALS[(ia + 3) % 8]}, {VALS[ib], VALS[(ib + 5) % 8]});
        end
      end
      idle();
    end

    // Long accumulation through 32-bit limit, guard byte and 40-bit wrap (R3, R9, R10)
    run(2'd1, 2'd1, 4'b1111, 1, 1, 1, 0, 1, 3'd6, 32'h80001000, 32'h80000100);
    for (int k = 0; k < 300; k++)
      run(2'd2, 2'd0, 4'b1111, 1, 1, 1, k[0], k[1], 3'(k), 32'h80001000, 32'h80000100);
    // Negative side, lane 0 extracts integer narrow without lane 1 extracting (R7, R10)
    for (int k = 0; k < 20; k++)
      run(2'd0, 2'd3, 4'b0000, 0, 1, 0, 1, 0, 3'(k), 32'h00007FFF, 32'h00007FFF);
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule